// File: doc/BRIEF.md
# Power Mode Controller for an 8-bit Microcontroller

This block owns the power control byte of a small 8-bit microcontroller and turns it into clock enables and gated clocks for two domains: the CPU core, and the peripherals (timers, serial unit, interrupt logic). The CPU reaches the byte over its special-function-register bus at address 0x87, with whole-byte reads and writes only. Two bits of the byte pick one of three operating states. Run clocks everything. Idle stops only the CPU. Power-down stops both domains.

Idle is left by an enabled interrupt, which also clears the idle bit, or by a hardware reset. Power-down is left only by a hardware reset. In power-down that reset acts at once, without waiting for a clock edge, and it is released in step with the clock. In run and idle the reset pin must be seen low on two successive clock edges before it is taken; a shorter glitch is dropped. The controller also overrides the address-latch and program-fetch strobes coming from the core while it sleeps. It brings out a synchronised system reset for the rest of the chip.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The control byte sits at SFR address 0x87. All 8 bits are written and read back as a byte, and the reset value is 0x00. A write to any other address leaves it unchanged, and a read of any other address returns 0x00.
- R2: Writing bit 0 = 1 (bit 1 = 0) moves the block to idle at the clock edge after the write edge. In idle idle_o = 1, cpu_clk_en_o = 0 and per_clk_en_o = 1. cpu_clk_o gives exactly one more rising edge after the write edge and then stays low.
- R3: Writing bit 1 = 1 moves the block to power-down at the edge after the write edge, whatever bit 0 holds (power-down wins). In power-down pdown_o = 1 and both clock enables are 0.
- R4: In idle, a clock edge where the global interrupt enable is set and irq_src_i & irq_en_i is nonzero returns the block to run. The same edge clears bit 0 and keeps the other bits. A source that is pending but masked, or any source while the global enable is clear, leaves the block in idle.
- R5: Power-down ignores every interrupt and stays in force until a hardware reset.
- R6: SFR writes are ignored whenever the CPU clock is off (idle or power-down).
- R7: In run, ale_o and psen_o follow ale_core_i and psen_core_i. In idle both are driven 1. In power-down both are driven 0.
- R8: In run and idle, rst_ni must be low on at least two successive rising edges, after a two-stage synchroniser, to be accepted. A low lasting one edge has no effect. An accepted reset drives rst_sync_no low, returns the block to run and clears the control byte to 0x00.
- R9: In power-down, rst_ni low drives rst_sync_no low at once, with no clock edge needed, and ends power-down. rst_sync_no rises again only on a clock edge after rst_ni is high.
- R10: per_clk_o keeps toggling in idle. In power-down neither gated clock gives any edge, and in run both do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Hardware reset pin, active low, asynchronous |
| sfr_addr_i | input | 8 | SFR bus address |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_rd_i | input | 1 | SFR read strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data, 0 when not selected |
| irq_src_i | input | NUM_IRQ | Pending interrupt sources |
| irq_en_i | input | NUM_IRQ | Per-source interrupt enables |
| irq_gen_i | input | 1 | Global interrupt enable |
| ale_core_i | input | 1 | Address-latch strobe from the core |
| psen_core_i | input | 1 | Program-fetch strobe from the core |
| ale_o | output | 1 | Address-latch strobe to the pin |
| psen_o | output | 1 | Program-fetch strobe to the pin |
| cpu_clk_en_o | output | 1 | CPU clock enable request |
| per_clk_en_o | output | 1 | Peripheral clock enable request |
| cpu_clk_o | output | 1 | Gated CPU clock |
| per_clk_o | output | 1 | Gated peripheral clock |
| rst_sync_no | output | 1 | System reset, active low |
| idle_o | output | 1 | Idle status flag |
| pdown_o | output | 1 | Power-down status flag |

## Verification
The hardest situation to reach is a reset pin that falls while the block is in power-down. Here the reset must act with no clock edge at all. Yet the same pin, in run or idle, must be filtered over two edges. The bench first sends the block into power-down with a byte write. It then drops rst_ni half a cycle away from any edge and samples rst_sync_no and pdown_o one nanosecond later, before any rising edge can have occurred. Against this it compares a one-edge glitch in run, which must leave a stored byte intact, and a two-edge low in idle, which must clear it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_e;

  localparam int IDL_BIT = 0;
  localparam int PD_BIT  = 1;

  localparam int DOM_CPU = 0;
  localparam int DOM_PER = 1;
  localparam int NUM_DOM = 2;
endpackage

// File: rtl/pmc_rst_ctrl.sv
module pmc_rst_ctrl #(
  parameter int MIN_LOW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  output logic rst_no
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW);
  localparam logic [CW-1:0] CNT_ACC = CW'(MIN_LOW - 1);

  logic          arst_n;
  logic [1:0]    sync_q;
  logic [CW-1:0] low_cnt_q;
  logic          rst_q;
  logic          accept;

  // pin acts asynchronously only while the clocks are stopped
  assign arst_n = rst_ni | ~pd_i;
  assign accept = ~sync_q[1] && (low_cnt_q >= CNT_ACC);

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) begin
      sync_q    <= '0;
      low_cnt_q <= '0;
      rst_q     <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rst_ni};
      if (sync_q[1])                low_cnt_q <= '0;
      else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
      if (accept)         rst_q <= 1'b0;
      else if (sync_q[1]) rst_q <= 1'b1;
    end
  end

  assign rst_no = rst_q;
endmodule

// File: rtl/pmc_sfr_reg.sv
module pmc_sfr_reg #(
  parameter int          AW   = 8,
  parameter int          DW   = 8,
  parameter logic [AW-1:0] ADDR = 8'h87
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_ok_i,
  input  logic          clr_idl_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] pcon_o
);
  import pmc_pkg::*;

  logic [DW-1:0] pcon_q;
  logic          sel;

  assign sel = (addr_i == ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcon_q <= '0;
    end else if (wr_i && sel && wr_ok_i) begin
      pcon_q <= wdata_i;
    end else if (clr_idl_i) begin
      pcon_q[IDL_BIT] <= 1'b0;
    end
  end

  assign rdata_o = (rd_i && sel) ? pcon_q : '0;
  assign pcon_o  = pcon_q;

  AST_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ok_i && !clr_idl_i) |=> $stable(pcon_q)); // R6
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm #(
  parameter int NUM_IRQ = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idl_i,
  input  logic               pd_i,
  input  logic [NUM_IRQ-1:0] irq_src_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               irq_gen_i,
  output pmc_pkg::pm_state_e state_o,
  output logic               clr_idl_o
);
  import pmc_pkg::*;

  pm_state_e state_q, state_d;
  logic      wake;

  assign wake = irq_gen_i & (|(irq_src_i & irq_en_i));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN: begin
        if (pd_i)       state_d = PM_DOWN;
        else if (idl_i) state_d = PM_IDLE;
      end
      PM_IDLE: begin
        if (pd_i)      state_d = PM_DOWN;
        else if (wake) state_d = PM_RUN;
      end
      PM_DOWN: state_d = PM_DOWN;
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PM_RUN;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign clr_idl_o = (state_q == PM_IDLE) && wake;

  AST_PD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_RUN && pd_i) |=> (state_q == PM_DOWN)); // R3
  AST_PD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_DOWN) |=> (state_q == PM_DOWN)); // R5
  AST_IDLE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_IDLE && !pd_i && irq_gen_i && |(irq_src_i & irq_en_i)) |=> (state_q == PM_RUN)); // R4
  AST_IDLE_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_IDLE && !pd_i && !(irq_gen_i && |(irq_src_i & irq_en_i))) |=> (state_q == PM_IDLE)); // R4
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_l;

  // enable captured in the low phase so the gated clock cannot glitch
  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int          NUM_IRQ     = 5,
  parameter int          SFR_AW      = 8,
  parameter int          SFR_DW      = 8,
  parameter logic [7:0]  PCON_ADDR   = 8'h87,
  parameter int          RST_MIN_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SFR_AW-1:0]  sfr_addr_i,
  input  logic               sfr_wr_i,
  input  logic               sfr_rd_i,
  input  logic [SFR_DW-1:0]  sfr_wdata_i,
  output logic [SFR_DW-1:0]  sfr_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_src_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               irq_gen_i,
  input  logic               ale_core_i,
  input  logic               psen_core_i,
  output logic               ale_o,
  output logic               psen_o,
  output logic               cpu_clk_en_o,
  output logic               per_clk_en_o,
  output logic               cpu_clk_o,
  output logic               per_clk_o,
  output logic               rst_sync_no,
  output logic               idle_o,
  output logic               pdown_o
);
  import pmc_pkg::*;

  logic               sys_rst_n;
  logic [SFR_DW-1:0]  pcon;
  pm_state_e          state;
  logic               clr_idl;
  logic               in_run, in_idle, in_down;
  logic [NUM_DOM-1:0] dom_en, dom_clk;

  assign in_run  = (state == PM_RUN);
  assign in_idle = (state == PM_IDLE);
  assign in_down = (state == PM_DOWN);

  pmc_rst_ctrl #(.MIN_LOW(RST_MIN_CYC)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pd_i   (in_down),
    .rst_no (sys_rst_n)
  );

  pmc_sfr_reg #(.AW(SFR_AW), .DW(SFR_DW), .ADDR(SFR_AW'(PCON_ADDR))) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (sys_rst_n),
    .addr_i    (sfr_addr_i),
    .wr_i      (sfr_wr_i),
    .rd_i      (sfr_rd_i),
    .wdata_i   (sfr_wdata_i),
    .wr_ok_i   (in_run),
    .clr_idl_i (clr_idl),
    .rdata_o   (sfr_rdata_o),
    .pcon_o    (pcon)
  );

  pmc_mode_fsm #(.NUM_IRQ(NUM_IRQ)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (sys_rst_n),
    .idl_i     (pcon[IDL_BIT]),
    .pd_i      (pcon[PD_BIT]),
    .irq_src_i (irq_src_i),
    .irq_en_i  (irq_en_i),
    .irq_gen_i (irq_gen_i),
    .state_o   (state),
    .clr_idl_o (clr_idl)
  );

  assign dom_en[DOM_CPU] = in_run;
  assign dom_en[DOM_PER] = ~in_down;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    pmc_clk_gate u_cg (
      .clk_i  (clk_i),
      .en_i   (dom_en[d]),
      .gclk_o (dom_clk[d])
    );
  end

  always_comb begin
    ale_o  = ale_core_i;
    psen_o = psen_core_i;
    if (in_idle) begin
      ale_o  = 1'b1;
      psen_o = 1'b1;
    end else if (in_down) begin
      ale_o  = 1'b0;
      psen_o = 1'b0;
    end
  end

  assign cpu_clk_en_o = dom_en[DOM_CPU];
  assign per_clk_en_o = dom_en[DOM_PER];
  assign cpu_clk_o    = dom_clk[DOM_CPU];
  assign per_clk_o    = dom_clk[DOM_PER];
  assign rst_sync_no  = sys_rst_n;
  assign idle_o       = in_idle;
  assign pdown_o      = in_down;

  AST_CPU_OFF_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (pcon[PD_BIT] || pcon[IDL_BIT]) && in_run && !sfr_wr_i |=> !cpu_clk_en_o); // R2
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
  localparam int NI = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0, wdata = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    rdata;
  logic [NI-1:0] src = '0, ena = '0;
  logic          gen = 1'b0;
  logic          ale_c = 1'b1, psen_c = 1'b0;
  logic          ale, psen, cpu_en, per_en, cpu_clk, per_clk, srst_n, idle, pdown;

  int n_chk = 0;
  int n_bad = 0;
  int cpu_cnt = 0;
  int per_cnt = 0;

  always #2.5 clk = ~clk;
  always @(posedge cpu_clk) cpu_cnt <= cpu_cnt + 1;
  always @(posedge per_clk) per_cnt <= per_cnt + 1;

  pwr_mode_ctrl #(.NUM_IRQ(NI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .sfr_addr_i(addr), .sfr_wr_i(wr), .sfr_rd_i(rd), .sfr_wdata_i(wdata), .sfr_rdata_o(rdata),
    .irq_src_i(src), .irq_en_i(ena), .irq_gen_i(gen),
    .ale_core_i(ale_c), .psen_core_i(psen_c), .ale_o(ale), .psen_o(psen),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .cpu_clk_o(cpu_clk), .per_clk_o(per_clk),
    .rst_sync_no(srst_n), .idle_o(idle), .pdown_o(pdown)
  );

  // {write data, expected state 0 run/1 idle/2 down, byte read back after recovery}
  localparam logic [17:0] VEC [0:6] = '{
    {8'h00, 2'd0, 8'h00},
    {8'hA4, 2'd0, 8'hA4},
    {8'h01, 2'd1, 8'h00},
    {8'hF1, 2'd1, 8'hF0},
    {8'h02, 2'd2, 8'h00},
    {8'h03, 2'd2, 8'h00},
    {8'h7C, 2'd0, 8'h7C}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic sfr_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic irq_pulse(input logic [NI-1:0] s, input logic [NI-1:0] e, input logic g);
    @(negedge clk); src = s; ena = e; gen = g;
    @(negedge clk); src = '0; ena = '0; gen = 1'b0;
  endtask

  task automatic pin_reset(input int cyc);
    @(negedge clk); rst_n = 1'b0;
    repeat (cyc) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_state(input string tag, input logic [1:0] s);
    chk({tag, " R2 idle flag"}, idle, s == 2'd1);
    chk({tag, " R3 down flag"}, pdown, s == 2'd2);
    chk({tag, " R2 cpu en"}, cpu_en, s == 2'd0);
    chk({tag, " R3 per en"}, per_en, s != 2'd2);
    chk({tag, " R7 ale"}, ale, (s == 2'd2) ? 1'b0 : (s == 2'd1) ? 1'b1 : ale_c);
    chk({tag, " R7 psen"}, psen, (s == 2'd2) ? 1'b0 : (s == 2'd1) ? 1'b1 : psen_c);
  endtask

  task automatic run_all();
    logic [7:0] rv;
    int c0, p0;
    bit dropped;
    // reset state
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 reset released", srst_n, 1'b1);
    check_state("reset", 2'd0);
    sfr_rd(8'h87, rv);
    chk("R1 reset value", rv, 8'h00);

    // table walk
    for (int i = 0; i < 7; i++) begin
      logic [7:0] wd, er;
      logic [1:0] es;
      {wd, es, er} = VEC[i];
      sfr_wr(8'h87, wd);
      @(negedge clk);
      check_state($sformatf("vec%0d", i), es);
      c0 = cpu_cnt; p0 = per_cnt;
      repeat (5) @(negedge clk);
      chk($sformatf("vec%0d R10 cpu edges", i), cpu_cnt - c0, (es == 2'd0) ? 5 : 0);
      chk($sformatf("vec%0d R10 per edges", i), per_cnt - p0, (es == 2'd2) ? 0 : 5);
      if (es == 2'd1) irq_pulse(5'b00100, 5'b00100, 1'b1);
      else if (es == 2'd2) pin_reset(4);
      chk($sformatf("vec%0d R4 back in run", i), {idle, pdown}, 2'b00);
      sfr_rd(8'h87, rv);
      chk($sformatf("vec%0d R1 read back", i), rv, er);
    end

    // R2: exactly one CPU edge after the write edge
    sfr_wr(8'h87, 8'h81);
    c0 = cpu_cnt;
    repeat (6) @(negedge clk);
    chk("R2 one trailing cpu edge", cpu_cnt - c0, 1);
    // R4 masked source and cleared global enable do not wake
    irq_pulse(5'b00010, 5'b00000, 1'b1);
    chk("R4 masked stays idle", idle, 1'b1);
    irq_pulse(5'b00010, 5'b00010, 1'b0);
    chk("R4 global off stays idle", idle, 1'b1);
    // R6 write while idle ignored
    sfr_wr(8'h87, 8'h02);
    @(negedge clk);
    chk("R6 idle write ignored", {idle, pdown}, 2'b10);
    irq_pulse(5'b10000, 5'b10000, 1'b1);
    sfr_rd(8'h87, rv);
    chk("R4 wake clears bit0 only", rv, 8'h80);

    // R1 other address
    sfr_wr(8'h86, 8'h02);
    @(negedge clk);
    chk("R1 other addr no mode", pdown, 1'b0);
    sfr_rd(8'h87, rv);
    chk("R1 other addr no write", rv, 8'h80);
    sfr_rd(8'h86, rv);
    chk("R1 other addr reads zero", rv, 8'h00);

    // R7 pass-through in run
    ale_c = 1'b0; psen_c = 1'b1;
    #1 chk("R7 ale follows core", ale, 1'b0);
    chk("R7 psen follows core", psen, 1'b1);
    ale_c = 1'b1; psen_c = 1'b0;

    // R8 one-edge glitch ignored
    sfr_wr(8'h87, 8'hA4);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    dropped = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!srst_n) dropped = 1'b1;
    end
    chk("R8 glitch no reset", dropped, 1'b0);
    sfr_rd(8'h87, rv);
    chk("R8 glitch keeps byte", rv, 8'hA4);

    // R8 two-edge low in idle accepted
    sfr_wr(8'h87, 8'hA5);
    @(negedge clk);
    chk("R8 entered idle", idle, 1'b1);
    pin_reset(2);
    chk("R8 reset ends idle", idle, 1'b0);
    sfr_rd(8'h87, rv);
    chk("R8 reset clears byte", rv, 8'h00);

    // R5 power-down ignores interrupts and writes
    sfr_wr(8'h87, 8'h03);
    @(negedge clk);
    irq_pulse(5'b11111, 5'b11111, 1'b1);
    chk("R5 irq ignored in down", pdown, 1'b1);
    sfr_wr(8'h87, 8'h00);
    @(negedge clk);
    chk("R6 down write ignored", pdown, 1'b1);

    // R9 asynchronous reset in power-down
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset asserted", srst_n, 1'b0);
    chk("R9 down left at once", pdown, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R9 release waits for edge", srst_n, 1'b0);
    repeat (8) @(negedge clk);
    chk("R9 released", srst_n, 1'b1);
    sfr_rd(8'h87, rv);
    chk("R9 byte cleared", rv, 8'h00);
    check_state("after down reset", 2'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule